// File: doc/BRIEF.md
# Serial-EEPROM Adapter Configuration Loader

After reset this block brings a network adapter's configuration out of a serial EEPROM and holds it in registers. It first releases the adapter core from reset and waits a fixed settling time. It then drives a byte-read engine, which handles the EEPROM wire protocol, through a sequence of single-byte random reads. Only one read is in flight at a time. The engine gets a one-cycle request together with an EEPROM byte offset. It answers with a one-cycle completion pulse that carries the data byte.

The loader makes eight reads in a fixed order. The first is the line-rate byte. The second is the buffer-RAM size byte. The last six are the station address bytes. The line-rate byte becomes a speed-select pin. The RAM byte is scaled to kilobytes, and the six address bytes are packed into one 48-bit value. A valid flag rises when the eighth byte has been stored. The flag and all the fields then hold until the next reset.

Top module: `cfg_loader`

## Requirements
- R1: `core_rel_o` is low while `rst_ni` is low. It goes high on the first clock edge after reset is released and then stays high.
- R2: No read request is issued until `core_rel_o` has been high for at least `ENABLE_WAIT` clock cycles.
- R3: The reads go out in this order. First the speed offset `OFF_SPEED`, then the RAM offset `OFF_RAM`, then `OFF_ADDR`, `OFF_ADDR+1`, and so on through `OFF_ADDR+5`. Each request is a one-cycle pulse on `rd_req_o`. A new request is never issued while an earlier one has not yet seen `rd_done_i`.
- R4: `speed_sel_o` is 1 when the speed byte is nonzero, which selects the low 4 Mbps rate. It is 0 when the speed byte is zero, which selects 16 Mbps.
- R5: `ram_kb_o` equals the RAM size byte multiplied by 128. Its low 7 bits are therefore always zero.
- R6: The first address byte read is stored in `sta_addr_o[47:40]`. Each later byte goes into the next lower octet, so the sixth byte lands in `sta_addr_o[7:0]`.
- R7: A read that the engine reports as failed returns 0xFF. The loader stores 0xFF as it is and does not retry. Exactly eight requests are issued per reset.
- R8: `cfg_valid_o` goes high on the clock edge that captures the eighth completion. It stays high until reset, and all configuration outputs stay unchanged while it is high.
- R9: While reset is asserted, `rd_req_o`, `cfg_valid_o`, `speed_sel_o`, `ram_kb_o` and `sta_addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_rel_o | output | 1 | Adapter core reset release |
| rd_req_o | output | 1 | One-cycle byte-read request to the engine |
| rd_addr_o | output | AW (8) | EEPROM byte offset for the request |
| rd_done_i | input | 1 | One-cycle read completion from the engine |
| rd_data_i | input | 8 | Byte returned with `rd_done_i` (0xFF on failure) |
| speed_sel_o | output | 1 | 1 = 4 Mbps, 0 = 16 Mbps |
| ram_kb_o | output | 15 | Buffer RAM size in kilobytes |
| sta_addr_o | output | 48 | Station address, first byte in the top octet |
| cfg_valid_o | output | 1 | All configuration fields loaded |

## Verification
Some behaviours are checked on every cycle by the assertions:
- `core_rel_o` stays high once it is set, and no request is issued before the settling time has passed.
- There is never more than one read outstanding.
- No request is issued once the valid flag is high, and the valid flag and the outputs are frozen from then on.
- The low seven bits of the RAM size are always zero.

Other behaviours can only be shown by the bench's scenarios, because they need an engine model with its own EEPROM image. These are the exact offset order, the decoding of each byte into its field, the octet order of the address, storing 0xFF for a failed read, and the valid flag rising in the cycle after the last completion.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } ld_state_e;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned HDR_READS  = 2;   // speed, ram
  localparam int unsigned RAM_SHIFT  = 7;   // x128
endpackage

// File: rtl/cfg_settle_timer.sv
module cfg_settle_timer #(
  parameter int unsigned WAIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(WAIT + 1) + 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!en_i)                       cnt_q <= '0;
    else if (cnt_q != CNT_W'(WAIT))       cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == CNT_W'(WAIT));
endmodule

// File: rtl/cfg_read_seq.sv
module cfg_read_seq
  import cfg_loader_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned NUM_READS  = 8,
  parameter logic [AW-1:0] OFF_SPEED = 8'h10,
  parameter logic [AW-1:0] OFF_RAM   = 8'h12,
  parameter logic [AW-1:0] OFF_ADDR  = 8'h20,
  localparam int unsigned IDX_W     = $clog2(NUM_READS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             settled_i,
  input  logic             rd_done_i,
  output logic             core_rel_o,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic             cap_o,
  output logic [IDX_W-1:0] cap_idx_o,
  output logic             valid_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_READS - 1);

  ld_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    addr_q;
  logic             rel_q;

  function automatic logic [AW-1:0] slot_offset(input logic [IDX_W-1:0] i);
    if (i == '0)                    return OFF_SPEED;
    else if (i == IDX_W'(1))        return OFF_RAM;
    else                            return OFF_ADDR + AW'(i) - AW'(HDR_READS);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SETTLE;
      idx_q   <= '0;
      addr_q  <= '0;
      rel_q   <= 1'b0;
    end else begin
      rel_q <= 1'b1;
      unique case (state_q)
        ST_SETTLE: if (settled_i) begin
          state_q <= ST_ISSUE;
          addr_q  <= slot_offset('0);
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (rd_done_i) begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            addr_q  <= slot_offset(idx_q + 1'b1);
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign core_rel_o = rel_q;
  assign rd_req_o   = (state_q == ST_ISSUE);
  assign rd_addr_o  = addr_q;
  assign cap_o      = (state_q == ST_WAIT) && rd_done_i;
  assign cap_idx_o  = idx_q;
  assign valid_o    = (state_q == ST_DONE);
endmodule

// File: rtl/cfg_field_store.sv
module cfg_field_store
  import cfg_loader_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned NUM_READS = HDR_READS + ADDR_BYTES,
  localparam int unsigned IDX_W     = $clog2(NUM_READS),
  localparam int unsigned RAM_W     = BYTE_W + RAM_SHIFT
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cap_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [BYTE_W-1:0]          data_i,
  output logic                       speed_sel_o,
  output logic [RAM_W-1:0]           ram_kb_o,
  output logic [BYTE_W*ADDR_BYTES-1:0] sta_addr_o
);
  logic              speed_q;
  logic [BYTE_W-1:0] ram_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      speed_q <= 1'b0;
      ram_q   <= '0;
    end else if (cap_i) begin
      if (idx_i == '0)         speed_q <= (data_i != '0);
      if (idx_i == IDX_W'(1))  ram_q   <= data_i;
    end
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_octet
    logic [BYTE_W-1:0] oct_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        oct_q <= '0;
      else if (cap_i && idx_i == IDX_W'(HDR_READS + g))   oct_q <= data_i;
    end
    // first byte read lands in the top octet
    assign sta_addr_o[BYTE_W*(ADDR_BYTES-1-g) +: BYTE_W] = oct_q;
  end

  assign speed_sel_o = speed_q;
  assign ram_kb_o    = {ram_q, {RAM_SHIFT{1'b0}}};
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned   ENABLE_WAIT = 100,
  parameter int unsigned   AW          = 8,
  parameter int unsigned   ADDR_BYTES  = 6,
  parameter logic [AW-1:0] OFF_SPEED   = 8'h10,
  parameter logic [AW-1:0] OFF_RAM     = 8'h12,
  parameter logic [AW-1:0] OFF_ADDR    = 8'h20,
  localparam int unsigned  NUM_READS   = HDR_READS + ADDR_BYTES,
  localparam int unsigned  IDX_W       = $clog2(NUM_READS),
  localparam int unsigned  RAM_W       = BYTE_W + RAM_SHIFT,
  localparam int unsigned  STA_W       = BYTE_W * ADDR_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              core_rel_o,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_done_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              speed_sel_o,
  output logic [RAM_W-1:0]  ram_kb_o,
  output logic [STA_W-1:0]  sta_addr_o,
  output logic              cfg_valid_o
);
  logic             settled;
  logic             cap;
  logic [IDX_W-1:0] cap_idx;

  cfg_settle_timer #(.WAIT(ENABLE_WAIT)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (core_rel_o),
    .done_o (settled)
  );

  cfg_read_seq #(
    .AW(AW), .NUM_READS(NUM_READS),
    .OFF_SPEED(OFF_SPEED), .OFF_RAM(OFF_RAM), .OFF_ADDR(OFF_ADDR)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .settled_i  (settled),
    .rd_done_i  (rd_done_i),
    .core_rel_o (core_rel_o),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .cap_o      (cap),
    .cap_idx_o  (cap_idx),
    .valid_o    (cfg_valid_o)
  );

  cfg_field_store #(.ADDR_BYTES(ADDR_BYTES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .idx_i       (cap_idx),
    .data_i      (rd_data_i),
    .speed_sel_o (speed_sel_o),
    .ram_kb_o    (ram_kb_o),
    .sta_addr_o  (sta_addr_o)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int unsigned ENABLE_WAIT = 100,
  parameter int unsigned RAM_W       = 15,
  parameter int unsigned STA_W       = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             core_rel_o,
  input logic             rd_req_o,
  input logic             rd_done_i,
  input logic             cfg_valid_o,
  input logic             speed_sel_o,
  input logic [RAM_W-1:0] ram_kb_o,
  input logic [STA_W-1:0] sta_addr_o
);
  localparam int unsigned CW = $clog2(ENABLE_WAIT + 1) + 1;

  logic [CW-1:0] rel_cnt;
  logic          pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_cnt <= '0;
      pending <= 1'b0;
    end else begin
      if (core_rel_o && rel_cnt != CW'(ENABLE_WAIT)) rel_cnt <= rel_cnt + 1'b1;
      if (rd_req_o)       pending <= 1'b1;
      else if (rd_done_i) pending <= 1'b0;
    end
  end

  // R1
  rel_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rel_o |=> core_rel_o);
  // R2
  req_after_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rel_cnt == CW'(ENABLE_WAIT)));
  // R3
  single_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !pending);
  // R3
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  // R5
  ram_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_kb_o[6:0] == 7'd0);
  // R7
  no_req_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> !rd_req_o);
  // R8
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |=> cfg_valid_o);
  // R8
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |=> ($stable(speed_sel_o) && $stable(ram_kb_o) && $stable(sta_addr_o)));
endmodule

bind cfg_loader cfg_loader_chk #(
  .ENABLE_WAIT(ENABLE_WAIT), .RAM_W(RAM_W), .STA_W(STA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .core_rel_o  (core_rel_o),
  .rd_req_o    (rd_req_o),
  .rd_done_i   (rd_done_i),
  .cfg_valid_o (cfg_valid_o),
  .speed_sel_o (speed_sel_o),
  .ram_kb_o    (ram_kb_o),
  .sta_addr_o  (sta_addr_o)
);

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;
  localparam int unsigned W      = 100;
  localparam logic [7:0]  O_SPD  = 8'h10;
  localparam logic [7:0]  O_RAM  = 8'h12;
  localparam logic [7:0]  O_ADR  = 8'h20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        core_rel_o, rd_req_o, rd_done_i, speed_sel_o, cfg_valid_o;
  logic [7:0]  rd_addr_o, rd_data_i;
  logic [14:0] ram_kb_o;
  logic [47:0] sta_addr_o;

  cfg_loader #(.ENABLE_WAIT(W), .OFF_SPEED(O_SPD), .OFF_RAM(O_RAM), .OFF_ADDR(O_ADR)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .core_rel_o(core_rel_o), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_done_i(rd_done_i), .rd_data_i(rd_data_i),
    .speed_sel_o(speed_sel_o), .ram_kb_o(ram_kb_o), .sta_addr_o(sta_addr_o),
    .cfg_valid_o(cfg_valid_o)
  );

  always #5 clk_i = ~clk_i;

  int unsigned n_chk = 0, n_err = 0;
  logic [7:0]  mem [256];
  logic [7:0]  fail_mask;
  logic [7:0]  req_log [16];
  int unsigned n_req;
  int unsigned rel_age;
  int unsigned first_req_age;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int unsigned slot);
    logic [7:0] off;
    off = (slot == 0) ? O_SPD : (slot == 1) ? O_RAM : O_ADR + 8'(slot - 2);
    return fail_mask[slot] ? 8'hFF : mem[off];
  endfunction

  function automatic logic [47:0] exp_sta();
    logic [47:0] v = '0;
    for (int i = 0; i < 6; i++) v = {v[39:0], exp_byte(2 + i)};
    return v;
  endfunction

  // byte-read engine model
  initial begin
    bit busy = 0;
    int unsigned lat = 0;
    logic [7:0] cur;
    rd_done_i = 1'b0;
    rd_data_i = 8'h00;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        busy = 0; rd_done_i = 1'b0; rel_age = 0; first_req_age = 0;
      end else begin
        if (core_rel_o) rel_age++;
        if (rd_done_i) begin
          rd_done_i = 1'b0;
          // R8: valid one cycle after last completion
          if (n_req == 8) chk(cfg_valid_o == 1'b1, "R8 valid after last", 64'(cfg_valid_o), 64'd1);
        end
        if (busy) begin
          lat--;
          if (lat == 0) begin
            busy = 0;
            rd_done_i = 1'b1;
            rd_data_i = fail_mask[n_req-1] ? 8'hFF : mem[cur];
            if (n_req == 8) chk(cfg_valid_o == 1'b0, "R8 valid not early", 64'(cfg_valid_o), 64'd0);
          end
        end
        if (rd_req_o) begin
          if (n_req == 0) first_req_age = rel_age;
          if (n_req < 16) req_log[n_req] = rd_addr_o;
          n_req++;
          cur  = rd_addr_o;
          busy = 1;
          lat  = 1 + ($urandom % 4);
        end
      end
    end
  end

  task automatic run_case(input string tag);
    int unsigned guard = 0;
    rst_ni = 1'b0;
    n_req = 0;
    repeat (3) @(negedge clk_i);
    // R9
    chk(!rd_req_o && !cfg_valid_o && !speed_sel_o && ram_kb_o == 0 && sta_addr_o == 0,
        "R9 reset outputs", {rd_req_o, cfg_valid_o, speed_sel_o, 13'(ram_kb_o), sta_addr_o}, 64'd0);
    // R1
    chk(core_rel_o == 1'b0, "R1 released in reset", 64'(core_rel_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(core_rel_o == 1'b1, "R1 release after reset", 64'(core_rel_o), 64'd1);
    while (!cfg_valid_o && guard < 2000) begin @(negedge clk_i); guard++; end
    chk(guard < 2000, {"R8 valid reached ", tag}, 64'(guard), 64'd0);
    // R2
    chk(first_req_age >= W, "R2 settle before first read", 64'(first_req_age), 64'(W));
    // R3
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e = (i == 0) ? O_SPD : (i == 1) ? O_RAM : O_ADR + 8'(i - 2);
      chk(req_log[i] == e, "R3 read order", 64'(req_log[i]), 64'(e));
    end
    // R4
    chk(speed_sel_o == (exp_byte(0) != 0), {"R4 speed ", tag}, 64'(speed_sel_o), 64'(exp_byte(0) != 0));
    // R5
    chk(ram_kb_o == 15'(exp_byte(1)) * 15'd128, {"R5 ram ", tag}, 64'(ram_kb_o), 64'(exp_byte(1)) * 128);
    // R6
    chk(sta_addr_o == exp_sta(), {"R6 station addr ", tag}, 64'(sta_addr_o), 64'(exp_sta()));
    repeat (25) @(negedge clk_i);
    // R7: no retry
    chk(n_req == 8, {"R7 request count ", tag}, 64'(n_req), 64'd8);
    // R8: held
    chk(cfg_valid_o && sta_addr_o == exp_sta() && ram_kb_o == 15'(exp_byte(1)) * 15'd128,
        "R8 outputs held", 64'(sta_addr_o), 64'(exp_sta()));
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    fill_mem();
    fail_mask = 8'h00;
    mem[O_SPD] = 8'h00; mem[O_RAM] = 8'h20;
    run_case("speed16");
    fill_mem(); mem[O_SPD] = 8'h01; mem[O_RAM] = 8'h00;
    run_case("speed4 ram0");
    fill_mem(); mem[O_SPD] = 8'h80; mem[O_RAM] = 8'hFF;
    run_case("ram max");
    fill_mem(); mem[O_SPD] = 8'h00; fail_mask = 8'b0000_0001;
    run_case("R7 fail speed");
    fill_mem(); fail_mask = 8'b0010_1010;
    run_case("R7 fail mixed");
    for (int k = 0; k < 5; k++) begin
      fill_mem();
      fail_mask = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      run_case("random");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule